// File: doc/BRIEF.md
# Dock Handshake Wrapper with Token Flush

This block sits between a set of input docks, a set of output docks and a small compute unit. Every dock runs a four-phase request/acknowledge handshake. A producer raises request with a word and the consumer raises acknowledge. The producer then drops request, and the consumer drops acknowledge. Each input bus carries one bit more than the data word. When that top bit is set, the item is a flush token and not an operand.

The wrapper decides in every cycle which inputs to acknowledge. If no input holds a token, the handshake runs as normal. When every input holds a data word and every output is empty, the unit fires. It consumes all inputs together and places the modular sum of the words on every output. If only some inputs hold a token, the wrapper discards the data words arriving on the other inputs and keeps the tokens waiting. Once every input holds a token, all tokens are consumed in the same cycle. The operand sets on the inputs therefore stay aligned across a flush. An output drops its request once its consumer acknowledges it.

Top module: `dock_flush_wrapper`

## Requirements
- R1: While `rst` is high (synchronous, active high), every `inAck` bit is 1 and every `outReq` bit is 0.
- R2: Bit WORD_W of each input lane (lane i occupies bits i*(WORD_W+1) upward) marks a flush token. An input is flushing when its request is high, that bit is 1 and its acknowledge is 0. A flushing input never takes part in a computation.
- R3: When no input is flushing, an input whose request is low and whose acknowledge is high lowers its acknowledge after the next clock edge.
- R4: The unit fires when four conditions hold: no input is flushing, every input holds a data word (request high, top bit 0, acknowledge low), every output is empty (request and acknowledge both low), and a clock edge occurs. After that edge every `inAck` bit is 1, every `outReq` bit is 1, and every output lane (WORD_W bits, lane j at bit j*WORD_W) carries the sum of the input words modulo 2^WORD_W.
- R5: While at least one input holds no word, the unit does not fire, and the acknowledge of every waiting data input stays low.
- R6: While any output is not empty, the unit does not fire. Waiting input words stay unacknowledged, and the output lanes keep their value.
- R7: An output whose request and acknowledge are both high lowers its request after the next clock edge.
- R8: When every input is flushing, all acknowledges rise after the next clock edge together, and no output request rises.
- R9: When some but not all inputs are flushing, each non-flushing input that holds a data word is acknowledged after the next edge, and its word is discarded. Flushing inputs keep their acknowledge low, and no output request rises.
- R10: While some but not all inputs are flushing, an input whose request is low and whose acknowledge is high lowers its acknowledge after the next edge.
- R11: After a partial flush has been resolved by a full flush, the next result is built only from words sent after the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inReq | input | NUM_IN | Request of each input dock |
| inData | input | NUM_IN*(WORD_W+1) | Input lanes; the top bit of each lane is the flush mark |
| inAck | output | NUM_IN | Acknowledge of each input dock |
| outReq | output | NUM_OUT | Request of each output dock |
| outData | output | NUM_OUT*WORD_W | Result lanes, one per output dock |
| outAck | input | NUM_OUT | Acknowledge from each output consumer |

## Verification
The hardest state to reach from the ports is a partial flush that has to be resolved without losing alignment. One input holds a token, another input has a data word pending, and a third input still has to deliver its own token. The directed test first sends a token on one input and data on the others, and checks that only the data is drained. It then withdraws those requests and sends tokens on the remaining inputs one at a time, passing through a state where two inputs flush and one is idle. Finally it sends a fresh operand set and checks that the sum contains none of the discarded words.

// File: rtl/dock_pkg.sv
package dock_pkg;

  // Unit-wide acknowledge policy, picked from how many inputs hold a token
  typedef enum logic [1:0] {
    POL_NORMAL     = 2'd0,
    POL_DRAIN_ALL  = 2'd1,
    POL_DRAIN_LIVE = 2'd2
  } policy_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
  } dp_strobe_t;

endpackage

// File: rtl/dock_policy.sv
module dock_policy #(
  parameter int NUM_IN = 3
) (
  input  logic [NUM_IN-1:0] flushing,
  output dock_pkg::policy_e policy
);
  import dock_pkg::*;

  always_comb begin
    if (&flushing)       policy = POL_DRAIN_ALL;
    else if (|flushing)  policy = POL_DRAIN_LIVE;
    else                 policy = POL_NORMAL;
  end

endmodule

// File: rtl/dock_datapath.sv
module dock_datapath #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  parameter int WORD_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_IN*(WORD_W+1)-1:0] inData,
  input  dock_pkg::dp_strobe_t        strobe,
  output logic [NUM_IN-1:0]           flagVec,
  output logic [NUM_OUT*WORD_W-1:0]   outData
);
  localparam int LANE_W = WORD_W + 1;

  logic [WORD_W-1:0] sumWord;

  // Token mark sits above the word in every lane
  for (genvar g = 0; g < NUM_IN; g++) begin : g_flag
    assign flagVec[g] = inData[g*LANE_W + WORD_W];
  end

  // Compute unit: modular sum of all input words
  always_comb begin
    sumWord = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      sumWord = sumWord + inData[i*LANE_W +: WORD_W];
    end
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) begin
        outData[g*WORD_W +: WORD_W] <= '0;
      end else if (strobe.load) begin
        outData[g*WORD_W +: WORD_W] <= sumWord;
      end
    end
  end

endmodule

// File: rtl/dock_control.sv
module dock_control #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_IN-1:0]    inReq,
  input  logic [NUM_IN-1:0]    flagVec,
  input  logic [NUM_OUT-1:0]   outAck,
  output logic [NUM_IN-1:0]    inAck,
  output logic [NUM_OUT-1:0]   outReq,
  output dock_pkg::dp_strobe_t strobe
);
  import dock_pkg::*;

  logic [NUM_IN-1:0]  effReq;
  logic [NUM_IN-1:0]  flushing;
  logic [NUM_IN-1:0]  holdsWord;
  logic [NUM_OUT-1:0] outEmpty;
  logic [NUM_IN-1:0]  nextAck;
  logic [NUM_OUT-1:0] nextReq;
  logic               fire;
  policy_e            policy;

  assign effReq    = inReq & ~flagVec;
  assign flushing  = inReq & flagVec & ~inAck;
  assign holdsWord = effReq & ~inAck;
  assign outEmpty  = ~outReq & ~outAck;

  dock_policy #(.NUM_IN(NUM_IN)) u_policy (
    .flushing(flushing),
    .policy  (policy)
  );

  assign fire = (policy == POL_NORMAL) && (&holdsWord) && (&outEmpty);
  assign strobe.load = fire;

  // Output side: retire acknowledged requests, fill on fire
  always_comb begin
    nextReq = outReq;
    for (int j = 0; j < NUM_OUT; j++) begin
      if (outReq[j] && outAck[j]) nextReq[j] = 1'b0;
    end
    if (fire) nextReq = '1;
  end

  // Input side: acknowledge policy
  always_comb begin
    nextAck = inAck;
    unique case (policy)
      POL_DRAIN_ALL: begin
        nextAck = '1;
      end
      POL_DRAIN_LIVE: begin
        for (int i = 0; i < NUM_IN; i++) begin
          if (!inReq[i] && inAck[i])  nextAck[i] = 1'b0;
          if (effReq[i] && !inAck[i]) nextAck[i] = 1'b1;
        end
      end
      default: begin
        for (int i = 0; i < NUM_IN; i++) begin
          if (!inReq[i] && inAck[i]) nextAck[i] = 1'b0;
        end
        if (fire) nextAck = '1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inAck  <= '1;
      outReq <= '0;
    end else begin
      inAck  <= nextAck;
      outReq <= nextReq;
    end
  end

endmodule

// File: rtl/dock_flush_wrapper.sv
module dock_flush_wrapper #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2,
  parameter int WORD_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_IN-1:0]            inReq,
  input  logic [NUM_IN*(WORD_W+1)-1:0] inData,
  output logic [NUM_IN-1:0]            inAck,
  output logic [NUM_OUT-1:0]           outReq,
  output logic [NUM_OUT*WORD_W-1:0]    outData,
  input  logic [NUM_OUT-1:0]           outAck
);
  import dock_pkg::*;

  logic [NUM_IN-1:0] flagVec;
  dp_strobe_t        strobe;

  dock_datapath #(
    .NUM_IN (NUM_IN),
    .NUM_OUT(NUM_OUT),
    .WORD_W (WORD_W)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .inData (inData),
    .strobe (strobe),
    .flagVec(flagVec),
    .outData(outData)
  );

  dock_control #(
    .NUM_IN (NUM_IN),
    .NUM_OUT(NUM_OUT)
  ) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .inReq  (inReq),
    .flagVec(flagVec),
    .outAck (outAck),
    .inAck  (inAck),
    .outReq (outReq),
    .strobe (strobe)
  );

endmodule

// File: rtl/dock_flush_wrapper_chk.sv
module dock_flush_wrapper_chk #(
  parameter int NUM_IN  = 3,
  parameter int NUM_OUT = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_IN-1:0]  inReq,
  input logic [NUM_IN-1:0]  flagVec,
  input logic [NUM_IN-1:0]  inAck,
  input logic [NUM_OUT-1:0] outReq,
  input logic [NUM_OUT-1:0] outAck
);
  logic [NUM_IN-1:0] flushNow;
  assign flushNow = inReq & flagVec & ~inAck;

  // R8: all inputs flushing -> all acknowledged together
  p_drain_all_r8: assert property (@(posedge clk) disable iff (rst)
    (&flushNow) |=> (&inAck));

  // R9 / R8: no output is filled while any token is pending
  p_no_fill_r9: assert property (@(posedge clk) disable iff (rst)
    (|flushNow) |=> ((outReq & ~$past(outReq)) == '0));

  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    // R9: a waiting token is not consumed during a partial flush
    p_token_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (flushNow[i] && !(&flushNow)) |=> !inAck[i]);

    // R3: normal return-to-zero of acknowledge
    p_ack_release_r3: assert property (@(posedge clk) disable iff (rst)
      (flushNow == '0 && !inReq[i] && inAck[i]) |=> !inAck[i]);

    // R5: a waiting data input is not acknowledged while an operand is missing
    p_wait_r5: assert property (@(posedge clk) disable iff (rst)
      (flushNow == '0 && !inAck[i] && !(&(inReq & ~flagVec))) |=> !inAck[i]);
  end

  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    // R7: acknowledged output request retires
    p_retire_r7: assert property (@(posedge clk) disable iff (rst)
      (outReq[j] && outAck[j]) |=> !outReq[j]);

    // R4: an output fills only together with consuming every input
    p_fill_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(outReq[j]) |-> ($past(inAck) == '0 && (&inAck)));
  end

endmodule

bind dock_flush_wrapper dock_flush_wrapper_chk #(
  .NUM_IN (NUM_IN),
  .NUM_OUT(NUM_OUT)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .inReq  (inReq),
  .flagVec(flagVec),
  .inAck  (inAck),
  .outReq (outReq),
  .outAck (outAck)
);

// File: tb/sim_dock_flush_wrapper.sv
module sim_dock_flush_wrapper;
  localparam int NI = 3;
  localparam int NO = 2;
  localparam int W  = 8;
  localparam int LW = W + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NI-1:0]    inReq  = '0;
  logic [NI*LW-1:0] inData = '0;
  logic [NI-1:0]    inAck;
  logic [NO-1:0]    outReq;
  logic [NO*W-1:0]  outData;
  logic [NO-1:0]    outAck = '0;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dock_flush_wrapper #(.NUM_IN(NI), .NUM_OUT(NO), .WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .inReq(inReq), .inData(inData), .inAck(inAck),
    .outReq(outReq), .outData(outData), .outAck(outAck)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int i, input bit req, input bit flag, input logic [W-1:0] w);
    inReq[i] = req;
    inData[i*LW +: LW] = {flag, w};
  endtask

  task automatic checkLanes(input string tag, input logic [W-1:0] exp);
    for (int j = 0; j < NO; j++) check(tag, 32'(outData[j*W +: W]), 32'(exp));
  endtask

  task automatic retire(input string tag);
    outAck = '1;
    step();
    check(tag, 32'(outReq), 0);
    outAck = '0;
  endtask

  task automatic dropAll(input string tag);
    inReq = '0;
    step();
    check(tag, 32'(inAck), 0);
  endtask

  task automatic fireSet(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                         input logic [W-1:0] sum);
    drive(0, 1, 0, a); drive(1, 1, 0, b); drive(2, 1, 0, c);
    step();
    check("R4 ack all", 32'(inAck), 32'h7);
    check("R4 fill", 32'(outReq), 32'h3);
    checkLanes("R4 sum", sum);
  endtask

  task automatic t_reset();
    step(); step();
    check("R1 ack during reset", 32'(inAck), 32'h7);
    check("R1 req during reset", 32'(outReq), 0);
    rst = 1'b0;
    step();
    check("R3 release after reset", 32'(inAck), 0);
  endtask

  task automatic t_fire();
    fireSet(8'd5, 8'd10, 8'd20, 8'd35);
    retire("R7 retire");
    dropAll("R3 release");
    fireSet(8'd200, 8'd100, 8'd0, 8'd44);
    retire("R7 retire wrap");
    dropAll("R3 release wrap");
  endtask

  task automatic t_missing();
    drive(0, 1, 0, 8'd1); drive(1, 1, 0, 8'd2);
    step(); step();
    check("R5 no ack while missing", 32'(inAck), 0);
    check("R5 no fill while missing", 32'(outReq), 0);
    drive(2, 1, 0, 8'd3);
    step();
    check("R5 fire when complete", 32'(outReq), 32'h3);
    checkLanes("R5 sum", 8'd6);
    retire("R7 retire");
    dropAll("R3 release");
  endtask

  task automatic t_backpressure();
    fireSet(8'd4, 8'd4, 8'd4, 8'd12);
    dropAll("R3 release");
    drive(0, 1, 0, 8'd1); drive(1, 1, 0, 8'd1); drive(2, 1, 0, 8'd1);
    step(); step();
    check("R6 inputs wait", 32'(inAck), 0);
    check("R6 outputs held", 32'(outReq), 32'h3);
    checkLanes("R6 lanes held", 8'd12);
    outAck = '1;
    step();
    check("R7 retire under load", 32'(outReq), 0);
    check("R6 ack still high blocks", 32'(inAck), 0);
    outAck = '0;
    step();
    check("R6 fire after empty", 32'(outReq), 32'h3);
    checkLanes("R6 new sum", 8'd3);
    retire("R7 retire");
    dropAll("R3 release");
  endtask

  task automatic t_flush_all();
    drive(0, 1, 1, 8'd9); drive(1, 1, 1, 8'd9); drive(2, 1, 1, 8'd9);
    step();
    check("R8 all tokens drained", 32'(inAck), 32'h7);
    check("R8 no fill", 32'(outReq), 0);
    dropAll("R8 release");
  endtask

  task automatic t_partial();
    drive(0, 1, 1, 8'd0); drive(1, 1, 0, 8'd7); drive(2, 1, 0, 8'd9);
    step();
    check("R9 live inputs drained", 32'(inAck), 32'h6);
    check("R9 no fill", 32'(outReq), 0);
    step();
    check("R9 token still held (R2)", 32'(inAck), 32'h6);
    inReq[1] = 1'b0; inReq[2] = 1'b0;
    step();
    check("R10 release in partial", 32'(inAck), 0);
    drive(1, 1, 1, 8'd0);
    step();
    check("R9 two tokens one idle", 32'(inAck), 0);
    check("R9 no fill two tokens", 32'(outReq), 0);
    drive(2, 1, 1, 8'd0);
    step();
    check("R8 realigned drain", 32'(inAck), 32'h7);
    dropAll("R8 release");
    drive(0, 1, 0, 8'd11); drive(1, 1, 0, 8'd22); drive(2, 1, 0, 8'd33);
    step();
    check("R11 fill after flush", 32'(outReq), 32'h3);
    checkLanes("R11 aligned sum", 8'd66);
    retire("R7 retire");
    dropAll("R3 release");
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fire();
    t_missing();
    t_backpressure();
    t_flush_all();
    t_partial();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule